// File: doc/BRIEF.md
# Wide Unsigned Multiply-Add with Split Result

This unit takes three 64-bit unsigned operands (A, B, C) and produces A times B plus C at full double width. The product is formed without truncation, C is widened with zeros to 128 bits before it is added, and the 128-bit sum comes back as two 64-bit words. The low word is the primary result and the high word is the secondary result. The unit has no flags and no status outputs, and it keeps no other state that software could see.

Operands enter on a valid/ready input channel, and results leave on a valid/ready output channel. The datapath has two stages. The first stage splits both multiplicands into limbs and registers every limb-by-limb partial product. The second stage shifts those partial products into place, adds the widened C, and registers the two halves at the output. When the output is not stalled, the unit accepts one operation per cycle and returns results in the order they were accepted. A stall at the output propagates back to the input.

Top module: `wide_mac`

## Requirements
- R1: The product of A and B is kept at the full 128 bits. With A = B = 2^64-1 and C = 0, the high word is 0xFFFFFFFFFFFFFFFE and the low word is 0x0000000000000001. With A = B = 2^32 and C = 0, the high word is 1 and the low word is 0.
- R2: C is zero-extended before the add, never sign-extended. With A = B = 0 and C = 2^64-1, the high word is 0 and the low word is 0xFFFFFFFFFFFFFFFF.
- R3: `out_lo` carries bits 63..0 of the 128-bit sum A*B + C.
- R4: `out_hi` carries bits 127..64 of the 128-bit sum A*B + C.
- R5: The sum never needs a 129th bit. With all three operands equal to 2^64-1, the high word is 0xFFFFFFFFFFFFFFFF and the low word is 0. With all three operands at zero, both words are 0.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and both result words hold their values.
- R7: When two operations are in flight and `out_ready` is low, `in_ready` is low and no further input is taken.
- R8: During reset and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R9: An accepted operation shows `out_valid` high two clock edges after the edge that accepted it. With `out_ready` held high, inputs are accepted back to back with no wait cycles. Results leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operand triple is offered |
| in_ready | output | 1 | The unit can take the offered triple this cycle |
| in_a | input | 64 | Multiplicand A, unsigned |
| in_b | input | 64 | Multiplicand B, unsigned |
| in_c | input | 64 | Addend C, unsigned, zero-extended |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_lo | output | 64 | Bits 63..0 of A*B + C |
| out_hi | output | 64 | Bits 127..64 of A*B + C |

## Verification
A partial product that is placed at the wrong limb offset shows up as a wrong high or low word on the first result that uses that limb pair. Cross-limb vectors such as 2^32 times 2^32 expose it two edges after acceptance. A lost carry between the halves, or a sign-extended C, corrupts `out_hi` on the very next result that carries across bit 64. A wrong valid bit in either pipeline register shows up at the handshake: a stalled result changes, `in_ready` stays high while both stages are full, or a result arrives out of order or with extra latency. Each of these is visible within a few cycles of the stimulus that triggers it.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
  // default operand width and limb width for the multiply-add datapath
  localparam int unsigned OPW_DEF  = 64;
  localparam int unsigned LIMB_DEF = 32;
endpackage

// File: rtl/wmac_pp_stage.sv
// Stage 1: split A and B into limbs and register every limb product.
module wmac_pp_stage #(
  parameter int unsigned OP_W   = wmac_pkg::OPW_DEF,
  parameter int unsigned LIMB_W = wmac_pkg::LIMB_DEF,
  localparam int unsigned NLIMB = OP_W / LIMB_W,
  localparam int unsigned NPP   = NLIMB * NLIMB,
  localparam int unsigned PP_W  = 2 * LIMB_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      advance,
  input  logic                      in_vld,
  input  logic [OP_W-1:0]           in_a,
  input  logic [OP_W-1:0]           in_b,
  input  logic [OP_W-1:0]           in_c,
  output logic                      stg_vld,
  output logic [NPP-1:0][PP_W-1:0]  stg_pp,
  output logic [OP_W-1:0]           stg_c
);
  function automatic logic [PP_W-1:0] mul_limb(input logic [LIMB_W-1:0] x,
                                                input logic [LIMB_W-1:0] y);
    return PP_W'(x) * PP_W'(y);
  endfunction

  logic [NPP-1:0][PP_W-1:0] pp_d;

  for (genvar i = 0; i < NLIMB; i++) begin : g_a
    for (genvar j = 0; j < NLIMB; j++) begin : g_b
      assign pp_d[i*NLIMB + j] = mul_limb(in_a[i*LIMB_W +: LIMB_W],
                                          in_b[j*LIMB_W +: LIMB_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_vld <= 1'b0;
      stg_pp  <= '0;
      stg_c   <= '0;
    end else if (advance) begin
      stg_vld <= in_vld;
      if (in_vld) begin
        stg_pp <= pp_d;
        stg_c  <= in_c;
      end
    end
  end
endmodule

// File: rtl/wmac_reduce.sv
// Stage 2 logic: align partial products and add zero-extended C.
module wmac_reduce #(
  parameter int unsigned OP_W   = wmac_pkg::OPW_DEF,
  parameter int unsigned LIMB_W = wmac_pkg::LIMB_DEF,
  localparam int unsigned NLIMB = OP_W / LIMB_W,
  localparam int unsigned NPP   = NLIMB * NLIMB,
  localparam int unsigned PP_W  = 2 * LIMB_W,
  localparam int unsigned RES_W = 2 * OP_W,
  localparam int unsigned EXT_W = RES_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      chk_vld,
  input  logic [NPP-1:0][PP_W-1:0]  pp,
  input  logic [OP_W-1:0]           addend,
  output logic [RES_W-1:0]          sum,
  output logic                      carry_out
);
  function automatic logic [EXT_W-1:0] place_pp(input logic [PP_W-1:0] p,
                                                 input int unsigned sh);
    return EXT_W'(p) << sh;
  endfunction

  logic [EXT_W-1:0] acc [NPP+1];

  assign acc[0] = EXT_W'(addend);

  for (genvar k = 0; k < NPP; k++) begin : g_acc
    localparam int unsigned SH = ((k / NLIMB) + (k % NLIMB)) * LIMB_W;
    assign acc[k+1] = acc[k] + place_pp(pp[k], SH);
  end

  assign sum       = acc[NPP][RES_W-1:0];
  assign carry_out = acc[NPP][RES_W];

  // R5
  no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |-> !carry_out);
endmodule

// File: rtl/wide_mac.sv
module wide_mac #(
  parameter int unsigned OP_W   = wmac_pkg::OPW_DEF,
  parameter int unsigned LIMB_W = wmac_pkg::LIMB_DEF,
  localparam int unsigned NLIMB = OP_W / LIMB_W,
  localparam int unsigned NPP   = NLIMB * NLIMB,
  localparam int unsigned PP_W  = 2 * LIMB_W,
  localparam int unsigned RES_W = 2 * OP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_a,
  input  logic [OP_W-1:0] in_b,
  input  logic [OP_W-1:0] in_c,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OP_W-1:0] out_lo,
  output logic [OP_W-1:0] out_hi
);
  logic                     stg_vld;
  logic [NPP-1:0][PP_W-1:0] stg_pp;
  logic [OP_W-1:0]          stg_c;
  logic [RES_W-1:0]         sum_w;
  logic                     carry_w;

  // handshake events, named for the checks below
  wire out_adv  = !out_valid || out_ready;
  wire stg_adv  = !stg_vld || out_adv;
  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;

  assign in_ready = stg_adv;

  wmac_pp_stage #(.OP_W(OP_W), .LIMB_W(LIMB_W)) u_pp (
    .clk(clk), .rst_n(rst_n), .advance(stg_adv), .in_vld(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .stg_vld(stg_vld), .stg_pp(stg_pp), .stg_c(stg_c)
  );

  wmac_reduce #(.OP_W(OP_W), .LIMB_W(LIMB_W)) u_red (
    .clk(clk), .rst_n(rst_n), .chk_vld(stg_vld), .pp(stg_pp),
    .addend(stg_c), .sum(sum_w), .carry_out(carry_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lo    <= '0;
      out_hi    <= '0;
    end else if (out_adv) begin
      out_valid <= stg_vld;
      if (stg_vld) begin
        out_lo <= sum_w[OP_W-1:0];
        out_hi <= sum_w[RES_W-1:OP_W];
      end
    end
  end

  // in-flight counter kept apart from the pipeline valid bits
  logic [1:0] occ_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) occ_cnt <= '0;
    else if (in_fire && !out_fire) occ_cnt <= occ_cnt + 2'd1;
    else if (!in_fire && out_fire) occ_cnt <= occ_cnt - 2'd1;
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lo) && $stable(out_hi)));

  // R7
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_cnt == 2'd2 && !out_ready) |-> !in_ready);

  // R7
  occ_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_cnt <= 2'd2);

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> ##2 out_valid);
endmodule

// File: tb/sim_wide_mac.sv
module sim_wide_mac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0, in_b = '0, in_c = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_lo, out_hi;

  always #2 clk = ~clk;  // 250 MHz

  wide_mac u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .out_valid(out_valid),
    .out_ready(out_ready), .out_lo(out_lo), .out_hi(out_hi)
  );

  int checks = 0;
  int errors = 0;
  int wait_cnt = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [127:0] exp_q [$];

  localparam logic [63:0] TA [8] = '{64'h0000_0000_0000_0003, 64'hFFFF_FFFF_0000_0000,
    64'h1234_5678_9ABC_DEF0, 64'h8000_0000_0000_0000, 64'h0000_0001_0000_0001,
    64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] TB [8] = '{64'h0000_0000_0000_0005, 64'h0000_0000_FFFF_FFFF,
    64'h0FED_CBA9_8765_4321, 64'h0000_0000_0000_0002, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0123_4567_89AB_CDEF, 64'h0000_0000_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] TC [8] = '{64'h0000_0000_0000_0007, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000,
    64'hFFFF_0000_FFFF_0000, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF};

  // bench restatement: plain 128-bit multiply of widened operands plus widened C
  function automatic logic [127:0] ref_mac(input logic [63:0] a, b, c);
    logic [127:0] wa, wb, wc;
    wa = {64'd0, a};
    wb = {64'd0, b};
    wc = {64'd0, c};
    return wa * wb + wc;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // caller is at posedge+1; returns at posedge+1 after the accepting edge
  task automatic send(input logic [63:0] a, b, c);
    in_a = a; in_b = b; in_c = c; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      wait_cnt++;
    end
    if (mon_en) exp_q.push_back(ref_mac(a, b, c));
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // R3 R4: every delivered result compared in order against the bench model
  always @(negedge clk) begin
    if (mon_en && out_valid && out_ready) begin
      logic [127:0] e;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected result", {out_hi, out_lo}, '0);
      end else begin
        e = exp_q.pop_front();
        chk(out_lo == e[63:0], "R3 low word", {64'd0, out_lo}, {64'd0, e[63:0]});
        chk(out_hi == e[127:64], "R4 high word", {64'd0, out_hi}, {64'd0, e[127:64]});
      end
    end
  end

  task automatic run_corner(input logic [63:0] a, b, c, ehi, elo, input string req);
    int n;
    send(a, b, c);
    n = 1;
    @(negedge clk);
    while (!out_valid && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk(n == 2, "R9 latency", 128'(n), 128'd2);
    chk(out_hi == ehi, req, {64'd0, out_hi}, {64'd0, ehi});
    chk(out_lo == elo, req, {64'd0, out_lo}, {64'd0, elo});
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 during reset
    chk(out_valid == 1'b0, "R8 out_valid in reset", 128'(out_valid), 128'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R8 first cycle after reset
    chk(out_valid == 1'b0, "R8 out_valid after reset", 128'(out_valid), 128'd0);
    chk(in_ready == 1'b1, "R8 in_ready after reset", 128'(in_ready), 128'd1);
    @(posedge clk); #1;

    // table walk, back to back with out_ready high (R3 R4 R9)
    mon_en = 1'b1;
    wait_cnt = 0;
    for (int i = 0; i < 8; i++) send(TA[i], TB[i], TC[i]);
    chk(wait_cnt == 0, "R9 back-to-back accept", 128'(wait_cnt), 128'd0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all results delivered", 128'(exp_q.size()), 128'd0);
    @(posedge clk); #1;

    // stall: R6 hold, R7 back-pressure, R9 order
    out_ready = 1'b0;
    send(64'd11, 64'd13, 64'd17);
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd1);
    fork
      send(64'd1 << 40, 64'd1 << 40, 64'd5);
      begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(in_ready == 1'b0, "R7 in_ready low when full", 128'(in_ready), 128'd0);
          chk(out_valid == 1'b1, "R6 valid held", 128'(out_valid), 128'd1);
          chk({out_hi, out_lo} == 128'd160, "R6 result held", {out_hi, out_lo}, 128'd160);
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
      end
    join
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R9 stalled results in order", 128'(exp_q.size()), 128'd0);
    @(posedge clk); #1;
    mon_en = 1'b0;

    // corners with literal expectations
    run_corner('1, '1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE, 64'd1, "R1 full product");
    run_corner(64'd1 << 32, 64'd1 << 32, 64'd0, 64'd1, 64'd0, "R1 cross-limb product");
    run_corner(64'd0, 64'd0, '1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R2 zero-extended C");
    run_corner('1, '1, '1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R5 all ones");
    run_corner(64'd0, 64'd0, 64'd0, 64'd0, 64'd0, "R5 all zero");

    done = 1'b1;
    report();
  end
endmodule